// File: doc/BRIEF.md
# Programmable Wait-State Bus Cycle Timer

This block sets the length of every CPU bus access. An access request carries a region code, a direction, a byte-lane pair, a narrow-bus flag, a multiplexed-bus flag and a DRAM-hit flag. The block works out how many bus clocks the access lasts. The count depends on per-area wait fields, an internal-memory wait bit and a set of fixed floors: writes, multiplexed external cycles and special-function-register cycles each have a minimum. When DRAM decoding is enabled and the access hits the DRAM region, the block also drives the active-low row strobe, the two column strobes and the write strobe for the whole access.

Firmware-visible settings are written through a narrow register-write port. A setting is sampled when an access is accepted, so a write only affects accesses that start after it. The access ends on the clock in which `acc_done` is high. A new request can be accepted on the clock after that.

Top module: `wait_bus_timer`

## Requirements
- R1: An external read (region codes 0 to 3) on a non-multiplexed bus lasts 1+N clocks, where N is the 2-bit wait field of that area, held in bits [2i+1:2i] of the wait register for area i.
- R2: A write always carries at least one wait state. A write to an area or to internal memory whose setting is zero waits lasts 2 clocks.
- R3: An external access with `req_mux`=1 uses at least two waits. Fields 0, 1 and 2 give 3 clocks and field 3 gives 4 clocks. The multiplexed flag has no effect on internal memory (code 4).
- R4: An internal-memory read (code 4) lasts 1 clock when the internal wait bit is 0 and 2 clocks when it is 1.
- R5: Region codes 5 to 7 (special-function registers) always last 2 clocks, whatever the internal wait bit holds.
- R6: `acc_busy` rises on the clock after a request is taken while idle. `acc_done` is high for exactly one clock, the last one of the access, and `acc_busy` is low on the next clock. A request raised while busy is ignored.
- R7: The strobes are driven only when the DRAM enable bit is 1 and `req_dram`=1. Otherwise all four strobes are high, and they are always high while idle. During an access they hold steady.
- R8: On a 16-bit bus (`req_narrow`=0), lane code 11 (both bytes) drives both column strobes low, 01 (even byte) drives only `casl_n` low, and 10 (odd byte) drives only `cash_n` low.
- R9: On an 8-bit bus (`req_narrow`=1), `casl_n` is low and `cash_n` is high for every DRAM access.
- R10: `ras_n` is low for every DRAM access. `dw_n` is low for writes and high for reads.
- R11: Config write port: `cfg_sel`=0 loads the wait register from `cfg_wdata`, `cfg_sel`=1 loads the internal wait bit from bit 0, and `cfg_sel`=2 loads the DRAM enable bit from bit 0. A write on the same clock edge that accepts a request does not change that request's length.
- R12: After reset, every area field is 3, the internal wait bit is 1, DRAM is disabled, and the block is idle with `acc_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Access request, taken while idle |
| req_region | input | 3 | Region code: 0-3 external area, 4 internal memory, 5-7 SFR |
| req_write | input | 1 | 1 for write, 0 for read |
| req_lane | input | 2 | Byte lanes: 01 even, 10 odd, 11 both |
| req_narrow | input | 1 | 1 when the external bus is 8 bits wide |
| req_mux | input | 1 | 1 when the access uses the multiplexed bus |
| req_dram | input | 1 | 1 when the access falls in the DRAM region |
| acc_busy | output | 1 | An access is in progress |
| acc_done | output | 1 | Last clock of the current access |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Low-byte column strobe, active low |
| cash_n | output | 1 | High-byte column strobe, active low |
| dw_n | output | 1 | DRAM write strobe, active low |

## Verification
A request is taken on the first clock edge that sees it while the block is idle. `acc_busy` and the strobes change on that same edge, so they are due one clock after the stimulus. `acc_done` is due 1+W clocks after the request, where W is the effective wait count. `acc_busy` falls one clock after that. The bench drives on falling edges and samples the strobes on the first falling edge after the accepting edge. It counts falling edges until `acc_done` is seen, which gives the length in clocks, and checks the idle state one falling edge later. Configuration writes are checked by the lengths of the accesses that follow them, including one write placed on the accepting edge itself.

// File: rtl/bwt_pkg.sv
// Shared constants and types for the wait-state bus cycle timer.
// Assumes a 3-bit region code with external areas starting at code 0.
package bwt_pkg;
    localparam int REGION_W = 3;
    localparam logic [REGION_W-1:0] REGION_INT = 3'd4;

    localparam int CFG_SEL_W = 2;
    localparam logic [CFG_SEL_W-1:0] CFG_WAITS = 2'd0;
    localparam logic [CFG_SEL_W-1:0] CFG_INTW  = 2'd1;
    localparam logic [CFG_SEL_W-1:0] CFG_DRAM  = 2'd2;

    localparam int LANE_W = 2;
    localparam logic [LANE_W-1:0] LANE_EVEN = 2'b01;
    localparam logic [LANE_W-1:0] LANE_ODD  = 2'b10;
    localparam logic [LANE_W-1:0] LANE_BOTH = 2'b11;

    typedef struct packed {
        logic ras_n;
        logic casl_n;
        logic cash_n;
        logic dw_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, casl_n: 1'b1, cash_n: 1'b1, dw_n: 1'b1};
endpackage

// File: rtl/bwt_cfg_regs.sv
// Configuration storage: per-area wait fields, internal wait bit, DRAM enable.
// Assumes writes come from a single-cycle strobe; reset gives the slowest timing.
module bwt_cfg_regs
    import bwt_pkg::*;
#(
    parameter int WREG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [WREG_W-1:0]    cfg_wdata,
    output logic [WREG_W-1:0]    wait_reg,
    output logic                 int_wait,
    output logic                 dram_en
);

    // Load the selected configuration target on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_reg <= '1;
            int_wait <= 1'b1;
            dram_en  <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                CFG_WAITS: wait_reg <= cfg_wdata;
                CFG_INTW:  int_wait <= cfg_wdata[0];
                CFG_DRAM:  dram_en  <= cfg_wdata[0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/bwt_wait_calc.sv
// Effective wait count for one request: programmed waits raised to the write
// minimum and, for external areas on the multiplexed bus, to the mux floor.
// Assumes region codes below NUM_AREAS are external and codes above the
// internal code are SFR.
module bwt_wait_calc
    import bwt_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    parameter int WAIT_W    = 2,
    parameter int CNT_W     = 3,
    parameter int MUX_FLOOR = 2,
    parameter int SFR_WAITS = 1,
    localparam int WREG_W   = NUM_AREAS * WAIT_W
) (
    input  logic [REGION_W-1:0] region,
    input  logic                write,
    input  logic                mux,
    input  logic [WREG_W-1:0]   wait_reg,
    input  logic                int_wait,
    output logic [CNT_W-1:0]    waits
);

    logic [WAIT_W-1:0] field [NUM_AREAS];

    for (genvar gi = 0; gi < NUM_AREAS; gi++) begin : g_field
        assign field[gi] = wait_reg[gi*WAIT_W +: WAIT_W];
    end

    logic [CNT_W-1:0] base;
    logic             is_ext;

    // Pick the programmed wait count for the addressed region.
    always_comb begin
        is_ext = 1'b0;
        if (region == REGION_INT) begin
            base = CNT_W'(int_wait);
        end else begin
            base = CNT_W'(SFR_WAITS);
        end
        for (int i = 0; i < NUM_AREAS; i++) begin
            if (region == REGION_W'(i)) begin
                base   = CNT_W'(field[i]);
                is_ext = 1'b1;
            end
        end
    end

    // Apply the write minimum and the multiplexed external floor.
    always_comb begin
        waits = base;
        if (write && waits < CNT_W'(1)) begin
            waits = CNT_W'(1);
        end
        if (is_ext && mux && waits < CNT_W'(MUX_FLOOR)) begin
            waits = CNT_W'(MUX_FLOOR);
        end
    end

endmodule

// File: rtl/bwt_strobe_dec.sv
// DRAM strobe pattern for one request, from direction, bus width and lanes.
// Assumes the pattern is held for the whole access by the caller.
module bwt_strobe_dec
    import bwt_pkg::*;
(
    input  logic              dram_en,
    input  logic              hit,
    input  logic              write,
    input  logic              narrow,
    input  logic [LANE_W-1:0] lane,
    output strobe_t           stb
);

    // Build the active-low strobes; all high unless DRAM is enabled and hit.
    always_comb begin
        stb = STROBE_IDLE;
        if (dram_en && hit) begin
            stb.ras_n = 1'b0;
            stb.dw_n  = ~write;
            if (narrow) begin
                stb.casl_n = 1'b0;
                stb.cash_n = 1'b1;
            end else begin
                stb.casl_n = ~lane[0];
                stb.cash_n = ~lane[1];
            end
        end
    end

endmodule

// File: rtl/wait_bus_timer.sv
// Top of the wait-state bus cycle timer. Takes a request while idle, holds
// busy for 1+waits clocks, pulses done on the last clock, and drives DRAM
// strobes for the whole access. Assumes the requester waits for done.
module wait_bus_timer
    import bwt_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    parameter int WAIT_W    = 2,
    parameter int MUX_FLOOR = 2,
    parameter int SFR_WAITS = 1,
    localparam int WREG_W   = NUM_AREAS * WAIT_W,
    localparam int CNT_W    = WAIT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [WREG_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    input  logic [REGION_W-1:0]  req_region,
    input  logic                 req_write,
    input  logic [LANE_W-1:0]    req_lane,
    input  logic                 req_narrow,
    input  logic                 req_mux,
    input  logic                 req_dram,
    output logic                 acc_busy,
    output logic                 acc_done,
    output logic                 ras_n,
    output logic                 casl_n,
    output logic                 cash_n,
    output logic                 dw_n
);

    logic [WREG_W-1:0] wait_reg;
    logic              int_wait;
    logic              dram_en;
    logic [CNT_W-1:0]  waits_d;
    strobe_t           stb_d;
    strobe_t           stb_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic              wr_q;

    bwt_cfg_regs #(.WREG_W(WREG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .wait_reg (wait_reg),
        .int_wait (int_wait),
        .dram_en  (dram_en)
    );

    bwt_wait_calc #(
        .NUM_AREAS(NUM_AREAS),
        .WAIT_W   (WAIT_W),
        .CNT_W    (CNT_W),
        .MUX_FLOOR(MUX_FLOOR),
        .SFR_WAITS(SFR_WAITS)
    ) u_calc (
        .region  (req_region),
        .write   (req_write),
        .mux     (req_mux),
        .wait_reg(wait_reg),
        .int_wait(int_wait),
        .waits   (waits_d)
    );

    bwt_strobe_dec u_dec (
        .dram_en(dram_en),
        .hit    (req_dram),
        .write  (req_write),
        .narrow (req_narrow),
        .lane   (req_lane),
        .stb    (stb_d)
    );

    // Access sequencer: accept while idle, count waits down, release on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            stb_q  <= STROBE_IDLE;
            wr_q   <= 1'b0;
        end else if (!busy_q) begin
            if (req_valid) begin
                busy_q <= 1'b1;
                cnt_q  <= waits_d;
                stb_q  <= stb_d;
                wr_q   <= req_write;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
            stb_q  <= STROBE_IDLE;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign acc_busy = busy_q;
    assign acc_done = busy_q && (cnt_q == '0);
    assign ras_n    = stb_q.ras_n;
    assign casl_n   = stb_q.casl_n;
    assign cash_n   = stb_q.cash_n;
    assign dw_n     = stb_q.dw_n;

endmodule

// File: rtl/bwt_checker.sv
// Protocol checks for the wait-state bus cycle timer, bound to its top.
// Assumes at most three wait states, so an access spans at most four clocks.
module bwt_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic wr_q,
    input logic ras_n,
    input logic casl_n,
    input logic cash_n,
    input logic dw_n
);

    logic [3:0] len_q;

    // Count completed clocks of the current access before its done clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (busy && !done) begin
            len_q <= len_q + 4'd1;
        end else begin
            len_q <= '0;
        end
    end

    p_idle_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ras_n && casl_n && cash_n && dw_n));

    p_strobe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable({ras_n, casl_n, cash_n, dw_n}));

    p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_start_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_cas_with_ras_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!casl_n || !cash_n || !dw_n) |-> !ras_n);

    p_write_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_q) |-> (len_q >= 4'd1));

    p_len_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_q <= 4'd3));

endmodule

bind wait_bus_timer bwt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (acc_busy),
    .done     (acc_done),
    .wr_q     (wr_q),
    .ras_n    (ras_n),
    .casl_n   (casl_n),
    .cash_n   (cash_n),
    .dw_n     (dw_n)
);

// File: tb/tb_wait_bus_timer.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of accesses, then directed cases.
module tb_wait_bus_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       req_valid;
    logic [2:0] req_region;
    logic       req_write;
    logic [1:0] req_lane;
    logic       req_narrow;
    logic       req_mux;
    logic       req_dram;
    logic       acc_busy;
    logic       acc_done;
    logic       ras_n;
    logic       casl_n;
    logic       cash_n;
    logic       dw_n;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wait_bus_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_region(req_region),
        .req_write(req_write), .req_lane(req_lane), .req_narrow(req_narrow),
        .req_mux(req_mux), .req_dram(req_dram), .acc_busy(acc_busy),
        .acc_done(acc_done), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
        .dw_n(dw_n)
    );

    typedef struct packed {
        logic [2:0] region;
        logic       wr;
        logic [1:0] lane;
        logic       narrow;
        logic       mux;
        logic       dram;
        logic [2:0] len;
        logic [3:0] stb;   // {ras_n, casl_n, cash_n, dw_n}
    } vec_t;

    // Wait register 0xE4: area0=0, area1=1, area2=2, area3=3; int bit 0; DRAM on.
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd1, 4'b1111},  // R1
        '{3'd1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd2, 4'b1111},  // R1
        '{3'd2, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd3, 4'b1111},  // R1
        '{3'd3, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd4, 4'b1111},  // R1
        '{3'd0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 3'd2, 4'b1111},  // R2
        '{3'd1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 3'd2, 4'b1111},  // R2
        '{3'd0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 3'd3, 4'b1111},  // R3
        '{3'd1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 3'd3, 4'b1111},  // R3
        '{3'd3, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 3'd4, 4'b1111},  // R3
        '{3'd4, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd1, 4'b1111},  // R4
        '{3'd4, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 3'd2, 4'b1111},  // R2
        '{3'd5, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 3'd2, 4'b1111},  // R5
        '{3'd0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 3'd1, 4'b0001},  // R8 R10
        '{3'd0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 3'd2, 4'b0010},  // R8 R10
        '{3'd0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 3'd1, 4'b0101},  // R8
        '{3'd1, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 3'd2, 4'b0010},  // R9
        '{3'd2, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 3'd3, 4'b0011},  // R9
        '{3'd4, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 3'd1, 4'b1111}   // R3 internal
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access: drive at a falling edge, sample strobes on clock 1,
    // count clocks to done, then report busy one clock after done.
    task automatic access(input logic [2:0] rg, input logic wr, input logic [1:0] ln,
                          input logic nr, input logic mx, input logic dr,
                          output int len, output logic [3:0] stb, output logic post_busy);
        @(negedge clk);
        req_valid = 1'b1; req_region = rg; req_write = wr; req_lane = ln;
        req_narrow = nr; req_mux = mx; req_dram = dr;
        @(negedge clk);
        req_valid = 1'b0;
        stb = {ras_n, casl_n, cash_n, dw_n};
        len = 1;
        while (!acc_done && len < 10) begin
            @(negedge clk);
            len++;
        end
        @(negedge clk);
        post_busy = acc_busy;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len;
        logic [3:0] stb;
        logic pb;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_region = '0; req_write = 1'b0; req_lane = 2'b11;
        req_narrow = 1'b0; req_mux = 1'b0; req_dram = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state at the ports.
        check("R12 busy", acc_busy, 0);
        check("R12 done", acc_done, 0);
        check("R12 strobes", {ras_n, casl_n, cash_n, dw_n}, 4'b1111);
        // R12: reset fields are 3 waits, int bit 1, DRAM off.
        access(3'd0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, len, stb, pb);
        check("R12 area0 len", len, 4);
        check("R12/R7 dram off strobes", stb, 4'b1111);
        access(3'd4, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, len, stb, pb);
        check("R12 int len", len, 2);
        // R5: SFR keeps two clocks with int bit 1.
        access(3'd6, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, len, stb, pb);
        check("R5 sfr int1 len", len, 2);

        // R11: program the table configuration.
        cfg_write(2'd0, 8'hE4);
        cfg_write(2'd1, 8'h00);
        cfg_write(2'd2, 8'h01);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].region, VECS[i].wr, VECS[i].lane, VECS[i].narrow,
                   VECS[i].mux, VECS[i].dram, len, stb, pb);
            check($sformatf("R1-table vec%0d len", i), len, int'(VECS[i].len));
            check($sformatf("R7 table vec%0d strobes", i), stb, VECS[i].stb);
            check($sformatf("R6 table vec%0d busy after done", i), pb, 0);
        end

        // R5: SFR code 7 ignores int bit 0 too.
        access(3'd7, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, len, stb, pb);
        check("R5 sfr code7 len", len, 2);

        // R7: DRAM hit flag low gives no strobes even when enabled.
        access(3'd0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, len, stb, pb);
        check("R7 no hit strobes", stb, 4'b1111);

        // R6: request raised mid-access is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_region = 3'd3; req_write = 1'b0; req_mux = 1'b0; req_dram = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_region = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 still busy clk3", acc_busy, 1);
        @(negedge clk);
        check("R6 done on clk4", acc_done, 1);
        @(negedge clk);
        check("R6 idle after done", acc_busy, 0);
        @(negedge clk);
        check("R6 ignored request not run", acc_busy, 0);

        // R11: config write on the accepting edge does not affect that access.
        @(negedge clk);
        req_valid = 1'b1; req_region = 3'd0; req_write = 1'b0; req_dram = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'hE7;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check("R11 old setting used", acc_done, 1);
        @(negedge clk);
        access(3'd0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, len, stb, pb);
        check("R11 new setting used", len, 4);

        // R4: internal bit set to 1 gives two clocks.
        cfg_write(2'd1, 8'h01);
        access(3'd4, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, len, stb, pb);
        check("R4 int1 len", len, 2);

        // R7: disabling DRAM removes strobes on a hit.
        cfg_write(2'd2, 8'h00);
        access(3'd1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, len, stb, pb);
        check("R7 disabled strobes", stb, 4'b1111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule